// File: doc/BRIEF.md
# Boot Image Stream Parser

This block sits behind a loader port and interprets a boot image that arrives as a stream of transfers. The first word is a key that must match the width the port is in. In 16-bit mode each transfer carries a full word. In byte mode each transfer carries one byte in bits 7:0, and two transfers form a word, low byte first. After the key the parser drops eight header words. It then captures a 32-bit entry point and copies a run of data blocks into memory through a write port that can stall.

A block is a word count, then the destination address as two halves with the high half first, then that many data words. The data words go to successive addresses. A count of zero closes the image. Once every pending write has left, the parser pulses `done` with the captured entry point. The parser then refuses further input until reset.

A key that is wrong for the selected width abandons the load. In that case the parser performs no writes and pulses `done` with the fixed fallback entry 0x003F7FF6, and `abort` stays high. Destination addresses and counts are taken as given.

Top module: `boot_image_parser`

## Requirements
- R1: After synchronous reset, `wr_valid`, `done` and `abort` are low and `in_ready` is high.
- R2: The first word is checked against 0x10AA when `byte_lane` is 0. When `byte_lane` is 1 it is checked against 0x08AA, built from the first byte (bits 7:0 of the transfer, the low byte) and then the second byte (the high byte).
- R3: Any other first word, including the key of the other width, causes a one-cycle `done` with `entry_addr` = 0x003F7FF6. `abort` then stays high until reset, and no write is issued.
- R4: The eight words after the key are consumed and have no effect on writes or on the entry point.
- R5: Words 10 and 11 give `entry_addr`, bits 31:16 first and then bits 15:0, and `entry_addr` holds this value when `done` pulses.
- R6: Each block is a count N, a destination high half and a destination low half, followed by N data words. These produce exactly N writes in stream order, to the destination address and the addresses after it.
- R7: A count of zero ends the image. `done` is high for exactly one cycle, and afterwards `in_ready` stays low until reset.
- R8: The count is in 16-bit words in both widths. In byte mode, bits 15:8 of each transfer are ignored.
- R9: Moving to the next write address increments only bits 21:0, wrapping within them. Bits 31:22 of the destination pass through unchanged.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold steady and the input stalls, so no write is lost or repeated.
- R11: `done` is never high while a write is still pending on the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_lane | input | 1 | 1: one byte per transfer in bits 7:0; 0: one word per transfer |
| in_valid | input | 1 | Input transfer offered |
| in_data | input | 16 | Input transfer payload |
| in_ready | output | 1 | Parser takes the transfer this cycle |
| wr_valid | output | 1 | Memory write pending |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 16 | Memory write data |
| wr_ready | input | 1 | Memory accepts the pending write |
| done | output | 1 | One-cycle pulse when parsing has ended |
| entry_addr | output | 32 | Entry point reported with done |
| abort | output | 1 | High after a key mismatch |

## Verification
The assertions assume that `byte_lane` is held constant from the release of reset until `done`. They also assume that a transfer stays unchanged while `in_valid` is high and `in_ready` is low. The bench changes the width only while reset is asserted, and it holds each transfer until it has seen the handshake. The bench drives `wr_ready` freely, including long low stretches that push back through to the input. The only stall the bench puts on the input side is gaps in `in_valid`.

// File: rtl/bip_pkg.sv
package bip_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        ST_KEY,
        ST_HDR,
        ST_ENT_HI,
        ST_ENT_LO,
        ST_COUNT,
        ST_DST_HI,
        ST_DST_LO,
        ST_COPY,
        ST_FLUSH,
        ST_HALT
    } parse_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    // Step an address inside its live low bits, leaving the rest untouched.
    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input int live);
        logic [ADDR_W-1:0] mask;
        mask = (ADDR_W'(1) << live) - ADDR_W'(1);
        return (a & ~mask) | ((a + ADDR_W'(1)) & mask);
    endfunction
endpackage

// File: rtl/bip_word_pack.sv
module bip_word_pack
    import bip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_lane,
    input  logic              open_i,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              w_valid,
    output logic [WORD_W-1:0] w_data,
    input  logic              w_ready
);
    localparam int HALF = WORD_W / 2;

    logic [HALF-1:0] lo_q;
    logic            have_lo;

    always_comb begin
        if (byte_lane) begin
            w_valid  = in_valid && have_lo;
            w_data   = {in_data[HALF-1:0], lo_q};
            in_ready = open_i && (have_lo ? w_ready : 1'b1);
        end else begin
            w_valid  = in_valid;
            w_data   = in_data;
            in_ready = open_i && w_ready;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_lo <= 1'b0;
            lo_q    <= '0;
        end else if (byte_lane && in_valid && in_ready) begin
            if (!have_lo) begin
                lo_q    <= in_data[HALF-1:0];
                have_lo <= 1'b1;
            end else begin
                have_lo <= 1'b0;
            end
        end
    end

    // R8
    word_mode_no_half_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_lane |=> !have_lo);
endmodule

// File: rtl/bip_wr_slot.sv
module bip_wr_slot
    import bip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  wr_req_t           push_req,
    output logic              can_take,
    output logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready
);
    wr_req_t held;
    logic    full;

    assign can_take = !full || wr_ready;
    assign busy     = full;
    assign wr_valid = full;
    assign wr_addr  = held.addr;
    assign wr_data  = held.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (push) begin
            full <= 1'b1;
            held <= push_req;
        end else if (wr_ready) begin
            full <= 1'b0;
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/bip_seq.sv
module bip_seq
    import bip_pkg::*;
#(
    parameter int                LIVE_BITS = 22,
    parameter int                HDR_WORDS = 8,
    parameter logic [WORD_W-1:0] KEY_WIDE  = 16'h10AA,
    parameter logic [WORD_W-1:0] KEY_NARROW = 16'h08AA,
    parameter logic [ADDR_W-1:0] FALLBACK  = 32'h003F_7FF6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_lane,
    input  logic              w_valid,
    input  logic [WORD_W-1:0] w_data,
    output logic              w_ready,
    output logic              open_o,
    input  logic              slot_can_take,
    input  logic              slot_busy,
    output logic              push,
    output wr_req_t           push_req,
    output logic              done,
    output logic              abort,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int HCW = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam logic [HCW-1:0] HDR_LAST = HCW'(HDR_WORDS - 1);

    parse_state_t      state;
    logic [HCW-1:0]    hdr_cnt;
    logic [ADDR_W-1:0] dst;
    logic [WORD_W-1:0] remain;
    logic              take;
    logic [WORD_W-1:0] key_exp;

    assign key_exp = byte_lane ? KEY_NARROW : KEY_WIDE;
    assign open_o  = (state != ST_FLUSH) && (state != ST_HALT);

    always_comb begin
        w_ready = open_o;
        if (state == ST_COPY) w_ready = slot_can_take;
    end

    assign take          = w_valid && w_ready;
    assign push          = take && (state == ST_COPY);
    assign push_req.addr = dst;
    assign push_req.data = w_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_KEY;
            hdr_cnt    <= '0;
            dst        <= '0;
            remain     <= '0;
            done       <= 1'b0;
            abort      <= 1'b0;
            entry_addr <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_KEY: if (take) begin
                    if (w_data == key_exp) begin
                        state   <= ST_HDR;
                        hdr_cnt <= '0;
                    end else begin
                        entry_addr <= FALLBACK;
                        abort      <= 1'b1;
                        done       <= 1'b1;
                        state      <= ST_HALT;
                    end
                end
                ST_HDR: if (take) begin
                    if (hdr_cnt == HDR_LAST) state <= ST_ENT_HI;
                    else hdr_cnt <= hdr_cnt + HCW'(1);
                end
                ST_ENT_HI: if (take) begin
                    entry_addr[ADDR_W-1:WORD_W] <= w_data;
                    state <= ST_ENT_LO;
                end
                ST_ENT_LO: if (take) begin
                    entry_addr[WORD_W-1:0] <= w_data;
                    state <= ST_COUNT;
                end
                ST_COUNT: if (take) begin
                    if (w_data == '0) state <= ST_FLUSH;
                    else begin
                        remain <= w_data;
                        state  <= ST_DST_HI;
                    end
                end
                ST_DST_HI: if (take) begin
                    dst[ADDR_W-1:WORD_W] <= w_data;
                    state <= ST_DST_LO;
                end
                ST_DST_LO: if (take) begin
                    dst[WORD_W-1:0] <= w_data;
                    state <= ST_COPY;
                end
                ST_COPY: if (take) begin
                    dst    <= step_addr(dst, LIVE_BITS);
                    remain <= remain - WORD_W'(1);
                    if (remain == WORD_W'(1)) state <= ST_COUNT;
                end
                ST_FLUSH: if (!slot_busy) begin
                    done  <= 1'b1;
                    state <= ST_HALT;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // R3
    fallback_entry_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> (entry_addr == FALLBACK));
    // R3
    abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> abort);
    // R7
    halt_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> !w_ready);
    // R6
    copy_count_live_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COPY) |-> (remain != '0));
endmodule

// File: rtl/boot_image_parser.sv
module boot_image_parser
    import bip_pkg::*;
#(
    parameter int                LIVE_BITS  = 22,
    parameter int                HDR_WORDS  = 8,
    parameter logic [WORD_W-1:0] KEY_WIDE   = 16'h10AA,
    parameter logic [WORD_W-1:0] KEY_NARROW = 16'h08AA,
    parameter logic [ADDR_W-1:0] FALLBACK   = 32'h003F_7FF6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_lane,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              done,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              abort
);
    logic              w_valid, w_ready, open_w;
    logic [WORD_W-1:0] w_data;
    logic              slot_can_take, slot_busy, push;
    wr_req_t           push_req;

    bip_word_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .byte_lane(byte_lane),
        .open_i   (open_w),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .w_valid  (w_valid),
        .w_data   (w_data),
        .w_ready  (w_ready)
    );

    bip_seq #(
        .LIVE_BITS (LIVE_BITS),
        .HDR_WORDS (HDR_WORDS),
        .KEY_WIDE  (KEY_WIDE),
        .KEY_NARROW(KEY_NARROW),
        .FALLBACK  (FALLBACK)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .byte_lane    (byte_lane),
        .w_valid      (w_valid),
        .w_data       (w_data),
        .w_ready      (w_ready),
        .open_o       (open_w),
        .slot_can_take(slot_can_take),
        .slot_busy    (slot_busy),
        .push         (push),
        .push_req     (push_req),
        .done         (done),
        .abort        (abort),
        .entry_addr   (entry_addr)
    );

    bip_wr_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_req (push_req),
        .can_take (slot_can_take),
        .busy     (slot_busy),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_ready (wr_ready)
    );

    // R11
    done_drained_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_valid);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    closed_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !in_ready);
    // R3
    abort_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> !wr_valid);
endmodule

// File: tb/sim_boot_image_parser.sv
module sim_boot_image_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_lane = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        done;
    logic [31:0] entry_addr;
    logic        abort;

    always #4 clk = ~clk;

    boot_image_parser u0 (
        .clk(clk), .rst(rst), .byte_lane(byte_lane),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .done(done), .entry_addr(entry_addr),
        .abort(abort)
    );

    typedef struct { logic [31:0] a; logic [15:0] d; } exp_t;

    exp_t        exp_q[$];
    logic [15:0] img[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    int          writes_seen = 0;
    logic [31:0] last_entry = '0;
    logic        last_abort = 1'b0;
    logic        prev_done = 1'b0;
    bit          bp_on = 0;
    bit          gap_on = 0;
    int          cyc = 0;
    string       cur_tag = "R6";

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] a);
        return {a[31:22], a[21:0] + 22'd1};
    endfunction

    // back-pressure pattern on the memory side
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 wr_ready = bp_on ? ((cyc % 5) < 2) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid && wr_ready) begin
                writes_seen++;
                if (exp_q.size() == 0) begin
                    check(0, cur_tag, "unexpected write addr", wr_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(wr_addr == e.a, cur_tag, "write addr", wr_addr, e.a);
                    check(wr_data == e.d, cur_tag, "write data", {16'h0, wr_data}, {16'h0, e.d});
                end
            end
            if (done) begin
                done_cnt++;
                last_entry = entry_addr;
                last_abort = abort;
                check(!wr_valid, "R11", "write pending at done", {31'h0, wr_valid}, 32'h0);
                if (prev_done) check(0, "R7", "done longer than one cycle", 32'h1, 32'h0);
            end
            prev_done = done;
        end else begin
            prev_done = 1'b0;
        end
    end

    task automatic do_reset(input bit bl);
        rst = 1'b1;
        in_valid = 1'b0;
        byte_lane = bl;
        exp_q.delete();
        img.delete();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic send_xfer(input logic [15:0] v);
        in_valid = 1'b1;
        in_data  = v;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (gap_on && (cyc % 2 == 0)) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_img();
        foreach (img[i]) begin
            if (byte_lane) begin
                send_xfer({8'hC3, img[i][7:0]});
                send_xfer({8'h5A, img[i][15:8]});
            end else begin
                send_xfer(img[i]);
            end
        end
    endtask

    task automatic put_header(input logic [15:0] key, input logic [31:0] ent);
        img.push_back(key);
        for (int i = 0; i < 8; i++) img.push_back(16'hBEE0 + 16'(i));
        img.push_back(ent[31:16]);
        img.push_back(ent[15:0]);
    endtask

    task automatic put_block(input logic [31:0] dst, input int n, input logic [15:0] seed);
        logic [31:0] a;
        img.push_back(16'(n));
        img.push_back(dst[31:16]);
        img.push_back(dst[15:0]);
        a = dst;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = a;
            e.d = seed ^ 16'(i * 16'h0101);
            img.push_back(e.d);
            exp_q.push_back(e);
            a = nxt(a);
        end
    endtask

    task automatic finish_load(input string tag, input logic [31:0] ent,
                               input bit ab, input int nwr, input int w0);
        int start;
        start = done_cnt;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            if (done_cnt != start) break;
        end
        check(done_cnt == start + 1, tag, "done count", 32'(done_cnt - start), 32'h1);
        check(last_entry == ent, tag, "entry", last_entry, ent);
        check(last_abort == ab, tag, "abort", {31'h0, last_abort}, {31'h0, ab});
        check(exp_q.size() == 0, tag, "writes missing", 32'(exp_q.size()), 32'h0);
        check(writes_seen - w0 == nwr, tag, "write count", 32'(writes_seen - w0), 32'(nwr));
        // R7: input stays closed after done
        #1 in_valid = 1'b1;
        in_data = 16'h0001;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!in_ready, "R7", "in_ready after done", {31'h0, in_ready}, 32'h0);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        int w0;
        // R1: reset state
        do_reset(1'b0);
        @(negedge clk);
        check(!wr_valid, "R1", "wr_valid", {31'h0, wr_valid}, 32'h0);
        check(!done, "R1", "done", {31'h0, done}, 32'h0);
        check(!abort, "R1", "abort", {31'h0, abort}, 32'h0);
        check(in_ready, "R1", "in_ready", {31'h0, in_ready}, 32'h1);
        @(posedge clk); #1;

        // R2 R4 R5 R6: word mode, two blocks
        do_reset(1'b0);
        cur_tag = "R6";
        w0 = writes_seen;
        put_header(16'h10AA, 32'h003F_8000);
        put_block(32'h003F_9010, 5, 16'h0001);
        put_block(32'h003F_8000, 2, 16'h7700);
        img.push_back(16'h0000);
        send_img();
        finish_load("R5", 32'h003F_8000, 1'b0, 7, w0);

        // R2 R8 R10: byte mode with memory back-pressure and gaps
        do_reset(1'b1);
        bp_on = 1; gap_on = 1;
        cur_tag = "R8";
        w0 = writes_seen;
        put_header(16'h08AA, 32'hA5C0_1234);
        put_block(32'h0000_0100, 4, 16'hF00D);
        put_block(32'h0012_3456, 1, 16'h8181);
        img.push_back(16'h0000);
        send_img();
        finish_load("R2", 32'hA5C0_1234, 1'b0, 5, w0);
        bp_on = 0; gap_on = 0;

        // R3: bad key
        do_reset(1'b0);
        w0 = writes_seen;
        img.push_back(16'h1234);
        send_img();
        finish_load("R3", 32'h003F_7FF6, 1'b1, 0, w0);

        // R3: narrow key offered while in word mode
        do_reset(1'b0);
        w0 = writes_seen;
        img.push_back(16'h08AA);
        send_img();
        finish_load("R3", 32'h003F_7FF6, 1'b1, 0, w0);

        // R3: wide key in byte mode
        do_reset(1'b1);
        w0 = writes_seen;
        img.push_back(16'h10AA);
        send_img();
        finish_load("R3", 32'h003F_7FF6, 1'b1, 0, w0);

        // R9 R10: address stepping confined to low 22 bits, heavy stall
        do_reset(1'b0);
        bp_on = 1;
        cur_tag = "R9";
        w0 = writes_seen;
        put_header(16'h10AA, 32'h0000_0040);
        put_block(32'h803F_FFFE, 4, 16'h1111);
        img.push_back(16'h0000);
        send_img();
        finish_load("R10", 32'h0000_0040, 1'b0, 4, w0);
        bp_on = 0;

        // R7 R4: immediate terminator, no writes
        do_reset(1'b1);
        cur_tag = "R7";
        w0 = writes_seen;
        put_header(16'h08AA, 32'h0001_0002);
        img.push_back(16'h0000);
        send_img();
        finish_load("R4", 32'h0001_0002, 1'b0, 0, w0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule